// File: doc/BRIEF.md
# ADC Serial Capture Bridge with Byte Readout

This block sits between a fast ADC with a serial data output and a slow host that has only a narrow parallel port. It watches two status lines from the converter: an active-high busy line and an active-low data-ready line. From these it forms a data-available flag. When that flag rises, a transaction window opens. The bridge then samples one serial bit on each system clock edge, most significant bit first, until it has a full 32-bit word.

When the last bit arrives, the finished word is copied into a holding register, separate from the shifter, and a fetch-ready flag is raised. The host picks one byte of the held word with a 2-bit address and reads it from an 8-bit bus. The byte selection is combinational, so the bus settles within one gate path of an address change. Host reads never reach the converter side. A read that runs into the next conversion still returns the previous word.

Top module: `adc_byte_bridge`

## Requirements
- R1: `data_avail_o` is high whenever `adc_busy_i` is low or `adc_drdy_n_i` is low, and low otherwise, with no clock delay.
- R2: If no capture is running, the clock edge that first sees `data_avail_o` high after it was low starts a capture. `adc_sclk_o` then stays high for exactly 32 consecutive cycles.
- R3: Bits are taken MSB first. The bit sampled on the first edge with `adc_sclk_o` high becomes bit 31 of the word, and the bit on the 32nd such edge becomes bit 0.
- R4: The edge that samples the 32nd bit also loads the holding register and sets `word_ready_o`. Both are visible in the cycle in which `adc_sclk_o` returns low.
- R5: `word_ready_o` clears on the edge that starts the next capture. The held word, and so every byte read from it, stays unchanged until that capture completes.
- R6: `rd_byte_o` follows `rd_addr_i` combinationally: address 0 gives bits 7:0, 1 gives 15:8, 2 gives 23:16 and 3 gives 31:24 of the held word.
- R7: `data_avail_o` staying high after a capture does not start another one. A rise of `data_avail_o` during a capture is ignored, and that capture still takes exactly 32 bits.
- R8: Changes of `rd_addr_i` never change `adc_sclk_o` and never alter the captured word.
- R9: Synchronous reset (`rst` high at a clock edge) clears the holding register and `word_ready_o` and leaves `adc_sclk_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; one serial bit per cycle |
| rst | input | 1 | Synchronous reset, active high |
| adc_busy_i | input | 1 | Converter busy status, active high |
| adc_drdy_n_i | input | 1 | Converter data-ready status, active low |
| adc_sdo_i | input | 1 | Serial data from the converter |
| adc_sclk_o | output | 1 | Serial bit strobe to the converter, high while shifting |
| rd_addr_i | input | 2 | Host byte select |
| rd_byte_o | output | 8 | Selected byte of the held word |
| data_avail_o | output | 1 | Converter has data (not busy or data-ready asserted) |
| word_ready_o | output | 1 | Held word is complete and may be fetched now |

## Verification
The hardest condition to create is a second rising edge of data-available that lands inside a running capture. The bench makes it by pulling the data-ready line high and then low again part way through the 32 bits. It then checks that the strobe still runs exactly 32 cycles and that the word is still correct. It also starts a new capture and, in the middle of the shifting, reads all four bytes to confirm that they still show the previous word. Between captures the bench sweeps the address while idle and checks that the strobe stays low and the next word is unaffected.

// File: rtl/adc_bridge_pkg.sv
package adc_bridge_pkg;

  typedef enum logic {
    CAP_IDLE  = 1'b0,
    CAP_SHIFT = 1'b1
  } cap_state_t;

  // Low bit index of byte lane `lane` for lanes of width `lane_w`.
  function automatic int lane_lsb(input int lane, input int lane_w);
    return lane * lane_w;
  endfunction

endpackage

// File: rtl/avail_detect.sv
module avail_detect (
  input  logic clk,
  input  logic rst,
  input  logic busy_i,
  input  logic drdy_n_i,
  output logic avail_o,
  output logic avail_rise_o
);

  logic avail_q;

  assign avail_o      = !busy_i || !drdy_n_i;
  assign avail_rise_o = avail_o && !avail_q;

  always_ff @(posedge clk) begin
    if (rst) avail_q <= 1'b1;  // no start seen in the first cycle after reset
    else     avail_q <= avail_o;
  end

endmodule

// File: rtl/serial_capture.sv
module serial_capture
  import adc_bridge_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig_i,
  input  logic              sdo_i,
  output logic              sclk_o,
  output logic              start_o,
  output logic              done_o,
  output logic [WORD_W-1:0] word_o
);

  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  cap_state_t        state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [WORD_W-1:0] shreg;

  function automatic logic [WORD_W-1:0] push_bit(input logic [WORD_W-1:0] w,
                                                 input logic b);
    return {w[WORD_W-2:0], b};
  endfunction

  assign sclk_o  = (state == CAP_SHIFT);
  assign start_o = trig_i && (state == CAP_IDLE);
  assign done_o  = (state == CAP_SHIFT) && (bit_cnt == LAST);
  assign word_o  = push_bit(shreg, sdo_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= CAP_IDLE;
      bit_cnt <= '0;
      shreg   <= '0;
    end else begin
      unique case (state)
        CAP_IDLE: begin
          if (start_o) begin
            state   <= CAP_SHIFT;
            bit_cnt <= '0;
          end
        end
        CAP_SHIFT: begin
          shreg   <= word_o;
          bit_cnt <= bit_cnt + 1'b1;
          if (done_o) state <= CAP_IDLE;
        end
        default: state <= CAP_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/word_hold.sv
module word_hold
  import adc_bridge_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int LANE_W = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              load_i,
  input  logic                              clear_i,
  input  logic [WORD_W-1:0]                 din_i,
  input  logic [$clog2(WORD_W/LANE_W)-1:0]  addr_i,
  output logic [LANE_W-1:0]                 byte_o,
  output logic                              ready_o,
  output logic [WORD_W-1:0]                 held_o
);

  localparam int LANES = WORD_W / LANE_W;

  logic [WORD_W-1:0] held;
  logic [LANE_W-1:0] lane [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = held[lane_lsb(g, LANE_W) +: LANE_W];
  end

  assign byte_o = lane[addr_i];
  assign held_o = held;

  always_ff @(posedge clk) begin
    if (rst) begin
      held    <= '0;
      ready_o <= 1'b0;
    end else begin
      if (load_i) begin
        held    <= din_i;
        ready_o <= 1'b1;
      end else if (clear_i) begin
        ready_o <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/adc_byte_bridge.sv
module adc_byte_bridge #(
  parameter int WORD_W = 32,
  parameter int LANE_W = 8
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             adc_busy_i,
  input  logic                             adc_drdy_n_i,
  input  logic                             adc_sdo_i,
  output logic                             adc_sclk_o,
  input  logic [$clog2(WORD_W/LANE_W)-1:0] rd_addr_i,
  output logic [LANE_W-1:0]                rd_byte_o,
  output logic                             data_avail_o,
  output logic                             word_ready_o
);

  logic              avail_rise;
  logic              cap_start;
  logic              cap_done;
  logic [WORD_W-1:0] cap_word;
  logic [WORD_W-1:0] hold_word;

  avail_detect u_avail (
    .clk          (clk),
    .rst          (rst),
    .busy_i       (adc_busy_i),
    .drdy_n_i     (adc_drdy_n_i),
    .avail_o      (data_avail_o),
    .avail_rise_o (avail_rise)
  );

  serial_capture #(.WORD_W(WORD_W)) u_cap (
    .clk     (clk),
    .rst     (rst),
    .trig_i  (avail_rise),
    .sdo_i   (adc_sdo_i),
    .sclk_o  (adc_sclk_o),
    .start_o (cap_start),
    .done_o  (cap_done),
    .word_o  (cap_word)
  );

  word_hold #(.WORD_W(WORD_W), .LANE_W(LANE_W)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .load_i  (cap_done),
    .clear_i (cap_start),
    .din_i   (cap_word),
    .addr_i  (rd_addr_i),
    .byte_o  (rd_byte_o),
    .ready_o (word_ready_o),
    .held_o  (hold_word)
  );

endmodule

// File: rtl/adc_bridge_checker.sv
module adc_bridge_checker #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              adc_busy_i,
  input logic              adc_drdy_n_i,
  input logic              data_avail_o,
  input logic              adc_sclk_o,
  input logic              word_ready_o,
  input logic              cap_start,
  input logic              cap_done,
  input logic [WORD_W-1:0] hold_word
);

  localparam int RUN_W = $clog2(WORD_W) + 1;
  logic [RUN_W-1:0] run_len;

  always_ff @(posedge clk) begin
    if (rst)             run_len <= '0;
    else if (adc_sclk_o) run_len <= run_len + 1'b1;
    else                 run_len <= '0;
  end

  // R1
  avail_map_chk: assert property (@(posedge clk) disable iff (rst)
    data_avail_o == (!adc_busy_i || !adc_drdy_n_i));

  // R2
  run_bound_chk: assert property (@(posedge clk) disable iff (rst)
    run_len <= RUN_W'(WORD_W));

  // R2
  run_exact_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(adc_sclk_o) |-> run_len == RUN_W'(WORD_W));

  // R4
  ready_after_shift_chk: assert property (@(posedge clk) disable iff (rst)
    cap_done |=> (word_ready_o && !adc_sclk_o));

  // R5
  ready_clear_chk: assert property (@(posedge clk) disable iff (rst)
    cap_start |=> (!word_ready_o && adc_sclk_o));

  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    adc_sclk_o |-> $stable(hold_word));

endmodule

bind adc_byte_bridge adc_bridge_checker #(.WORD_W(WORD_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .adc_busy_i   (adc_busy_i),
  .adc_drdy_n_i (adc_drdy_n_i),
  .data_avail_o (data_avail_o),
  .adc_sclk_o   (adc_sclk_o),
  .word_ready_o (word_ready_o),
  .cap_start    (cap_start),
  .cap_done     (cap_done),
  .hold_word    (hold_word)
);

// File: tb/tb_adc_byte_bridge.sv
module tb_adc_byte_bridge;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       busy = 1'b1;
  logic       drdy_n = 1'b1;
  logic       sdo = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       sclk;
  logic [7:0] rbyte;
  logic       avail;
  logic       ready;

  int total = 0;
  int bad = 0;
  logic [31:0] last_word = 32'h0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_byte_bridge dut (
    .clk          (clk),
    .rst          (rst),
    .adc_busy_i   (busy),
    .adc_drdy_n_i (drdy_n),
    .adc_sdo_i    (sdo),
    .adc_sclk_o   (sclk),
    .rd_addr_i    (addr),
    .rd_byte_o    (rbyte),
    .data_avail_o (avail),
    .word_ready_o (ready)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Read all four bytes through the address port and compare with a word (R6).
  task automatic check_word(input string req, input logic [31:0] w);
    for (int a = 0; a < 4; a++) begin
      addr = 2'(a);
      #1;
      check(req, {24'h0, rbyte}, {24'h0, w[a*8 +: 8]});
    end
    addr = 2'd0;
  endtask

  // Drive one conversion; optional glitch raises data-available again mid-capture.
  task automatic run_capture(input logic [31:0] w, input bit glitch, input bit mid_read);
    int hi = 0;
    @(negedge clk);
    drdy_n = 1'b0;
    @(posedge clk);
    for (int i = 31; i >= 0; i--) begin
      @(negedge clk);
      if (sclk) hi++;
      sdo = w[i];
      if (glitch && i == 20) drdy_n = 1'b1;
      if (glitch && i == 18) drdy_n = 1'b0;
      if (mid_read && i == 15) begin
        check("R5 ready low during capture", {31'h0, ready}, 32'h0);
        check_word("R5 old word held during capture", last_word);
      end
      @(posedge clk);
    end
    @(negedge clk);
    check("R2 strobe high 32 cycles", hi, 32);
    check("R2 strobe low after 32 bits", {31'h0, sclk}, 32'h0);
    check("R4 word ready after capture", {31'h0, ready}, 32'h1);
    check_word(glitch ? "R7 word intact despite mid edge" : "R3 MSB-first word", w);
    last_word = w;
  endtask

  task automatic t_reset;
    check("R9 strobe low in reset", {31'h0, sclk}, 32'h0);
    check("R9 ready low in reset", {31'h0, ready}, 32'h0);
    check_word("R9 held word cleared", 32'h0);
  endtask

  task automatic t_avail_map;
    for (int k = 0; k < 4; k++) begin
      busy = k[0];
      drdy_n = k[1];
      #1;
      check("R1 data available map", {31'h0, avail}, {31'h0, (!k[0]) || (!k[1])});
      drdy_n = 1'b1;
      busy = 1'b1;
      @(negedge clk);
      @(negedge clk);
    end
  endtask

  task automatic t_no_retrigger;
    for (int n = 0; n < 6; n++) begin
      @(negedge clk);
      check("R7 no restart while available stays high", {31'h0, sclk}, 32'h0);
    end
    drdy_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_addr_idle;
    for (int n = 0; n < 8; n++) begin
      @(negedge clk);
      addr = 2'(n);
      #1;
      check("R8 address sweep leaves strobe low", {31'h0, sclk}, 32'h0);
    end
    addr = 2'd0;
    check_word("R8 held word unchanged by address sweep", last_word);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_avail_map();
    // R2 R3 R4 R6: first capture, asymmetric bytes
    run_capture(32'hA1B2C3D4, 1'b0, 1'b0);
    t_no_retrigger();
    // R5: new capture, read during shifting
    run_capture(32'h80000001, 1'b0, 1'b1);
    drdy_n = 1'b1;
    @(negedge clk);
    t_addr_idle();
    // R7: extra rising edge inside a capture
    run_capture(32'h5A3C96F0, 1'b1, 1'b1);
    drdy_n = 1'b1;
    @(negedge clk);
    run_capture(32'hFFFF0000, 1'b0, 1'b0);
    drdy_n = 1'b1;
    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule